// File: doc/BRIEF.md
# Paired Host Address Counters

This block keeps the two byte-address counters behind a host port's data path. One counter gives the memory address for reads and the other gives the memory address for writes. The transfer engine always takes `mem_rd_addr` for memory reads and `mem_wr_addr` for memory writes, whatever the mode. The host front end loads the counters through an address write, reads them back through an address read, and moves them forward with increment strobes that come from data accesses.

The mode input `dual_en` carries bit 9 of the port's control register: 0 selects aliased (single) mode and 1 selects separate (dual) mode. In aliased mode the host sees one address register. A load writes both counters, any valid increment advances both, and a read-back returns the read counter. In separate mode the host reaches each counter on its own, and `tgt_wr_sel` picks which one: 0 picks the read counter and 1 picks the write counter.

The read increment strobe is raised when a word is fetched from memory into the read buffer, not when the host consumes that word. The write increment strobe is raised when a written word is committed. Both strobes count only when the access code on `acc_code` is the auto-increment data code.

Top module: `hxa_addr_pair`

## Requirements
- R1: After reset, `mem_rd_addr`, `mem_wr_addr` and `haddr_rdata` are all zero.
- R2: With `dual_en`=0, a host address write loads `haddr_wdata` into both counters on the next clock edge, whatever the value of `tgt_wr_sel`.
- R3: With `dual_en`=1, a host address write loads only the counter picked by `tgt_wr_sel` (0 picks read, 1 picks write), and the other counter keeps its value.
- R4: With `dual_en`=0, a host address read places the read counter's value at the request cycle into `haddr_rdata` one clock later, whatever the value of `tgt_wr_sel`.
- R5: With `dual_en`=1, a host address read returns the counter picked by `tgt_wr_sel`, one clock later. Without a read request, `haddr_rdata` holds its value.
- R6: An increment strobe advances a counter by 4 only when `acc_code` is 2'b01. Under codes 00, 10 and 11 the strobes leave both counters unchanged.
- R7: With `dual_en`=0, either increment strobe, or both together, advances both counters by exactly 4 in that cycle.
- R8: With `dual_en`=1, `fetch_rd` advances only the read counter and `store_wr` advances only the write counter.
- R9: When a load and an increment reach the same counter in the same cycle, the load wins. In dual mode the counter that is not loaded still takes its own increment.
- R10: Counters wrap modulo 2^32: an increment from 32'hFFFF_FFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_en | input | 1 | Control register bit 9: 0 aliased, 1 separate |
| tgt_wr_sel | input | 1 | Separate-mode target: 0 read counter, 1 write counter |
| haddr_wr | input | 1 | Host address write request |
| haddr_wdata | input | 32 | Host address write value |
| haddr_rd | input | 1 | Host address read request |
| haddr_rdata | output | 32 | Registered host address read value |
| acc_code | input | 2 | Access type of the current data access |
| fetch_rd | input | 1 | Word fetched into the read buffer |
| store_wr | input | 1 | Word committed from the write buffer |
| mem_rd_addr | output | 32 | Address for memory reads |
| mem_wr_addr | output | 32 | Address for memory writes |

## Verification
Aliased mode with both strobes in one cycle is driven directly. A design that adds twice there lets the counters run 8 ahead. Loads that coincide with increments are also driven directly. Getting the priority wrong would leave a loaded counter 4 past the value the host wrote, and gating the priority across both counters would stall the untargeted counter in separate mode. Increment strobes under code 11 are mixed into random traffic, where a counter that ignores the code drifts from the model. A wrap case from 32'hFFFF_FFFC and read-backs in aliased mode with the write select set expose a wrong carry width and a read-back that follows the select bit.

// File: rtl/hxa_pkg.sv
package hxa_pkg;
   typedef enum logic [1:0] {
      ACC_CTRL     = 2'b00,
      ACC_DATA_INC = 2'b01,
      ACC_ADDR     = 2'b10,
      ACC_DATA_FIX = 2'b11
   } acc_code_e;

   typedef enum logic {
      SLOT_RD = 1'b0,
      SLOT_WR = 1'b1
   } slot_e;

   localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/hxa_route.sv
module hxa_route
   import hxa_pkg::*;
#(
   parameter logic [1:0] INC_CODE = ACC_DATA_INC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dual_en,
   input  logic                 tgt_wr_sel,
   input  logic                 host_ld,
   input  logic [1:0]           acc_code,
   input  logic                 fetch_rd,
   input  logic                 store_wr,
   output logic [NUM_SLOTS-1:0] ld,
   output logic [NUM_SLOTS-1:0] inc
);
   logic code_ok;
   logic any_inc;

   assign code_ok = (acc_code == INC_CODE);
   assign any_inc = (fetch_rd | store_wr) & code_ok;

   always_comb begin
      if (dual_en) begin
         ld[SLOT_RD]  = host_ld & ~tgt_wr_sel;
         ld[SLOT_WR]  = host_ld &  tgt_wr_sel;
         inc[SLOT_RD] = fetch_rd & code_ok;
         inc[SLOT_WR] = store_wr & code_ok;
      end else begin
         ld  = {NUM_SLOTS{host_ld}};
         inc = {NUM_SLOTS{any_inc}};
      end
   end

   // R6
   code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_code != INC_CODE) |-> (inc == '0));
   // R3
   dual_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dual_en |-> !(ld[SLOT_RD] && ld[SLOT_WR]));
   // R7
   alias_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_en |-> (ld[SLOT_RD] == ld[SLOT_WR] && inc[SLOT_RD] == inc[SLOT_WR]));
endmodule

// File: rtl/hxa_counter.sv
module hxa_counter #(
   parameter int W    = 32,
   parameter int STEP = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] STEP_V = W'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("hxa_counter: STEP must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (ld)  q <= ld_val;
      else if (inc) q <= q + STEP_V;
   end

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(ld_val)));
   // R10
   step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && inc) |=> (q == $past(q) + STEP_V));
   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !inc) |=> $stable(q));
endmodule

// File: rtl/hxa_rdback.sv
module hxa_rdback #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_req,
   input  logic         dual_en,
   input  logic         tgt_wr_sel,
   input  logic [W-1:0] rd_val,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] rdata
);
   logic [W-1:0] pick;

   assign pick = (dual_en && tgt_wr_sel) ? wr_val : rd_val;

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_req) rdata <= pick;
   end

   // R4
   alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !dual_en) |=> (rdata == $past(rd_val)));
   // R5
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rdata));
endmodule

// File: rtl/hxa_addr_pair.sv
module hxa_addr_pair
   import hxa_pkg::*;
#(
   parameter int         ADDR_W   = 32,
   parameter int         STEP     = 4,
   parameter logic [1:0] INC_CODE = ACC_DATA_INC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dual_en,
   input  logic              tgt_wr_sel,
   input  logic              haddr_wr,
   input  logic [ADDR_W-1:0] haddr_wdata,
   input  logic              haddr_rd,
   output logic [ADDR_W-1:0] haddr_rdata,
   input  logic [1:0]        acc_code,
   input  logic              fetch_rd,
   input  logic              store_wr,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic [ADDR_W-1:0] mem_wr_addr
);
   logic [NUM_SLOTS-1:0] ld;
   logic [NUM_SLOTS-1:0] inc;
   logic [ADDR_W-1:0]    cnt [NUM_SLOTS];

   if (ADDR_W < 2) begin : g_bad_width
      $error("hxa_addr_pair: ADDR_W too small");
   end

   hxa_route #(.INC_CODE(INC_CODE)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .dual_en    (dual_en),
      .tgt_wr_sel (tgt_wr_sel),
      .host_ld    (haddr_wr),
      .acc_code   (acc_code),
      .fetch_rd   (fetch_rd),
      .store_wr   (store_wr),
      .ld         (ld),
      .inc        (inc)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      hxa_counter #(.W(ADDR_W), .STEP(STEP)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (ld[s]),
         .ld_val (haddr_wdata),
         .inc    (inc[s]),
         .q      (cnt[s])
      );
   end

   assign mem_rd_addr = cnt[SLOT_RD];
   assign mem_wr_addr = cnt[SLOT_WR];

   hxa_rdback #(.W(ADDR_W)) u_rdback (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (haddr_rd),
      .dual_en    (dual_en),
      .tgt_wr_sel (tgt_wr_sel),
      .rd_val     (mem_rd_addr),
      .wr_val     (mem_wr_addr),
      .rdata      (haddr_rdata)
   );

   // R2
   alias_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (haddr_wr && !dual_en) |=> (mem_rd_addr == $past(haddr_wdata) &&
                                  mem_wr_addr == $past(haddr_wdata)));
   // R8
   dual_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_en && !haddr_wr && !store_wr) |=> $stable(mem_wr_addr));
endmodule

// File: tb/hxa_addr_pair_test.sv
module hxa_addr_pair_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dual_en = 1'b0, tgt_wr_sel = 1'b0;
   logic        haddr_wr = 1'b0, haddr_rd = 1'b0;
   logic [31:0] haddr_wdata = '0;
   logic [1:0]  acc_code = 2'b00;
   logic        fetch_rd = 1'b0, store_wr = 1'b0;
   logic [31:0] haddr_rdata, mem_rd_addr, mem_wr_addr;

   int n_run = 0, n_fail = 0;
   logic [31:0] e_rd = '0, e_wr = '0, e_rb = '0;
   bit done = 0;

   always #2 clk = ~clk;

   hxa_addr_pair uut (
      .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .tgt_wr_sel(tgt_wr_sel),
      .haddr_wr(haddr_wr), .haddr_wdata(haddr_wdata), .haddr_rd(haddr_rd),
      .haddr_rdata(haddr_rdata), .acc_code(acc_code), .fetch_rd(fetch_rd),
      .store_wr(store_wr), .mem_rd_addr(mem_rd_addr), .mem_wr_addr(mem_wr_addr)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // expected next state from the requirements
   function automatic void model_step();
      logic ok;
      logic [31:0] nrd, nwr;
      ok = (acc_code == 2'b01);
      nrd = e_rd; nwr = e_wr;
      if (haddr_rd) e_rb = (dual_en && tgt_wr_sel) ? e_wr : e_rd;
      if (!dual_en) begin
         if (ok && (fetch_rd || store_wr)) begin nrd = e_rd + 4; nwr = e_wr + 4; end
         if (haddr_wr) begin nrd = haddr_wdata; nwr = haddr_wdata; end
      end else begin
         if (ok && fetch_rd) nrd = e_rd + 4;
         if (ok && store_wr) nwr = e_wr + 4;
         if (haddr_wr && !tgt_wr_sel) nrd = haddr_wdata;
         if (haddr_wr &&  tgt_wr_sel) nwr = haddr_wdata;
      end
      e_rd = nrd; e_wr = nwr;
   endfunction

   task automatic cyc(string tag, logic d, logic s, logic w, logic [31:0] wd,
                      logic r, logic [1:0] c, logic fr, logic sw);
      dual_en = d; tgt_wr_sel = s; haddr_wr = w; haddr_wdata = wd;
      haddr_rd = r; acc_code = c; fetch_rd = fr; store_wr = sw;
      model_step();
      @(posedge clk); #1;
      check({tag, " rd"}, mem_rd_addr, e_rd);
      check({tag, " wr"}, mem_wr_addr, e_wr);
      check({tag, " rb"}, haddr_rdata, e_rb);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      #1;
      check("R1 rd", mem_rd_addr, 32'h0);
      check("R1 wr", mem_wr_addr, 32'h0);
      check("R1 rb", haddr_rdata, 32'h0);
      rst_n = 1'b1;
      // R2: aliased load ignores select
      cyc("R2", 0, 1, 1, 32'h1000_0040, 0, 2'b10, 0, 0);
      // R4: aliased read with select high returns read counter
      cyc("R4", 0, 1, 0, 0, 1, 2'b10, 0, 0);
      // R7: both strobes advance by 4 once
      cyc("R7", 0, 0, 0, 0, 0, 2'b01, 1, 1);
      cyc("R7", 0, 1, 0, 0, 0, 2'b01, 0, 1);
      // R6: code 11 does nothing
      cyc("R6", 0, 0, 0, 0, 0, 2'b11, 1, 1);
      // R3: separate loads
      cyc("R3", 1, 0, 1, 32'h0000_2000, 0, 2'b10, 0, 0);
      cyc("R3", 1, 1, 1, 32'h0000_8000, 0, 2'b10, 0, 0);
      // R5: separate reads
      cyc("R5", 1, 1, 0, 0, 1, 2'b10, 0, 0);
      cyc("R5", 1, 0, 0, 0, 1, 2'b10, 0, 0);
      cyc("R5 hold", 1, 1, 0, 0, 0, 2'b10, 0, 0);
      // R8: separate increments
      cyc("R8", 1, 0, 0, 0, 0, 2'b01, 1, 0);
      cyc("R8", 1, 0, 0, 0, 0, 2'b01, 0, 1);
      // R9: load beats increment; other counter still moves
      cyc("R9", 1, 1, 1, 32'h0000_0100, 0, 2'b01, 1, 1);
      cyc("R9", 0, 0, 1, 32'h0000_0200, 0, 2'b01, 1, 1);
      // R10: wrap
      cyc("R10", 0, 0, 1, 32'hFFFF_FFFC, 0, 2'b10, 0, 0);
      cyc("R10", 0, 0, 0, 0, 0, 2'b01, 1, 0);
      // random traffic (R6 R7 R8 R9)
      for (int i = 0; i < 3000; i++) begin
         cyc("R6/R7/R8 random", 1'($urandom), 1'($urandom),
             ($urandom % 8) == 0, $urandom & 32'hFFFF_FFFC,
             ($urandom % 4) == 0, 2'($urandom), 1'($urandom), 1'($urandom));
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule